// File: doc/BRIEF.md
# Per-Key Offset Calibrator

This block finds an offset code for each key of a 32-key capacitive matrix. It runs a binary successive-approximation search one key at a time. For each trial it puts a candidate code on its acquisition port and asks the burst sequencer for one measurement. It then waits for the sequencer's done strobe and reads a one-bit comparator verdict that says whether the amplified signal is still above the target. When a key's search ends, the result goes into a volatile code bank. The scanning logic can read that bank at any time through a combinational read port.

A full pass over every key, in ascending key order, starts automatically out of reset and again whenever the host pulses a start input. A key can also be marked as suspect, for example when it was touched or covered while it was being calibrated. When the suspect mark is removed (a falling edge on its suspect line), the key joins a pending set and is recalibrated on its own. Keys in the pending set are served from the lowest index upward, and no other key's code changes. A busy output shows that calibration work is running or waiting to run.

Top module: `key_offset_cal`

## Requirements
- R1: Reset clears every stored code to zero and arms a full pass, so busy is high in the first cycle after reset and the pass starts without a host command.
- R2: A key search makes exactly CODE_W trials, testing bits from the MSB down to the LSB. Each trial code is the bits already kept with the bit under test also set. acq_req stays high, and acq_code and acq_key stay unchanged, until acq_done is seen.
- R3: On acq_done the bit under test is kept when cmp_above is 1 and dropped when it is 0. After the LSB trial the resulting code is stored for that key.
- R4: A full pass calibrates keys 0 through NKEYS-1 in ascending order, one key at a time.
- R5: A start_all pulse arms a full pass. If one arrives during a pass, the key in progress finishes and the pass then restarts at key 0.
- R6: A falling edge on key_suspect[k] queues key k. A suspect line that is held high queues nothing. Queued keys are calibrated alone, lowest index first, and the codes of all other keys stay unchanged.
- R7: An armed full pass, and a pass in progress, take priority over queued single keys. The queued keys are served after the pass ends.
- R8: rd_code returns the stored code of rd_key. During a key's recalibration it returns that key's previous code. The new code appears in the cycle after the final acq_done.
- R9: busy is high while a trial is outstanding, a full pass is armed or in progress, or any key is queued. Otherwise it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_all | input | 1 | Host pulse that arms a full calibration pass |
| key_suspect | input | NKEYS | Per-key suspect flags; the falling edge queues a recalibration |
| acq_req | output | 1 | Acquisition request to the burst sequencer, held until done |
| acq_key | output | KW | Key under calibration |
| acq_code | output | CODE_W | Trial offset code for the current acquisition |
| acq_done | input | 1 | One-cycle strobe that ends the current acquisition |
| cmp_above | input | 1 | Comparator verdict, valid with acq_done: signal above target |
| rd_key | input | KW | Key index for readout |
| rd_code | output | CODE_W | Stored offset code of rd_key |
| busy | output | 1 | Calibration running or pending |

## Verification
A wrong kept bit or a wrong trial mask shows on acq_code at the next trial, one clock after the acq_done that caused it. It then shows on rd_code one clock after that key's last trial. A lost or doubled queue entry, or a wrong priority choice, shows on acq_key in the first trial after the block returns to idle. A stale pass or request flag shows on busy in the same cycle. The bench compares every output against a behavioural model on every clock, so each of these faults is reported within one or two cycles of the point where it starts.

// File: rtl/cal_pkg.sv
package cal_pkg;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_TRIAL = 1'b1
    } cal_state_t;

    typedef enum logic [1:0] {
        JOB_NONE   = 2'd0,
        JOB_FULL   = 2'd1,
        JOB_NEXT   = 2'd2,
        JOB_SINGLE = 2'd3
    } cal_job_t;

    function automatic cal_job_t pick_job(input cal_state_t st,
                                          input logic full_armed,
                                          input logic in_pass,
                                          input logic queued);
        cal_job_t j;
        j = JOB_NONE;
        if (st == ST_IDLE) begin
            if (full_armed)      j = JOB_FULL;
            else if (in_pass)    j = JOB_NEXT;
            else if (queued)     j = JOB_SINGLE;
        end
        return j;
    endfunction

endpackage

// File: rtl/cal_queue.sv
module cal_queue #(
    parameter int NKEYS = 32,
    localparam int KW = $clog2(NKEYS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NKEYS-1:0] key_suspect,
    input  logic             take,
    output logic             any,
    output logic [KW-1:0]    pick
);
    logic [NKEYS-1:0] seen_q;
    logic [NKEYS-1:0] released;
    logic [NKEYS-1:0] pend;
    logic [NKEYS-1:0] clr_mask;

    for (genvar g = 0; g < NKEYS; g++) begin : g_edge
        always_ff @(posedge clk) begin
            if (rst) seen_q[g] <= 1'b0;
            else     seen_q[g] <= key_suspect[g];
        end
        assign released[g] = seen_q[g] & ~key_suspect[g];
    end

    always_comb begin
        pick = '0;
        for (int i = NKEYS - 1; i >= 0; i--) begin
            if (pend[i]) pick = KW'(i);
        end
    end

    assign any      = |pend;
    assign clr_mask = take ? (NKEYS'(1) << pick) : '0;

    always_ff @(posedge clk) begin
        if (rst) pend <= '0;
        else     pend <= (pend & ~clr_mask) | released;
    end

    p_release_queues_r6: assert property (@(posedge clk) disable iff (rst)
        (|released) |=> ((pend & $past(released)) == $past(released)));

    p_take_only_pending_r6: assert property (@(posedge clk) disable iff (rst)
        take |-> any);

endmodule

// File: rtl/sar_engine.sv
module sar_engine #(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step,
    input  logic              cmp_above,
    output logic [CODE_W-1:0] trial_code,
    output logic [CODE_W-1:0] result,
    output logic              last
);
    logic [CODE_W-1:0] kept;
    logic [CODE_W-1:0] mask;

    assign trial_code = kept | mask;
    assign last       = mask[0];
    assign result     = cmp_above ? (kept | mask) : kept;

    always_ff @(posedge clk) begin
        if (rst) begin
            kept <= '0;
            mask <= '0;
        end else if (load) begin
            kept <= '0;
            mask <= {1'b1, {(CODE_W-1){1'b0}}};
        end else if (step) begin
            if (cmp_above) kept <= kept | mask;
            mask <= mask >> 1;
        end
    end

    p_mask_shift_r2: assert property (@(posedge clk) disable iff (rst)
        (step && !last && !load) |=> (mask == ($past(mask) >> 1)));

    p_keep_bit_r3: assert property (@(posedge clk) disable iff (rst)
        (step && cmp_above && !load) |=> ((kept & $past(mask)) == $past(mask)));

    p_load_msb_r2: assert property (@(posedge clk) disable iff (rst)
        load |=> (mask[CODE_W-1] && kept == '0));

endmodule

// File: rtl/code_bank.sv
module code_bank #(
    parameter int NKEYS  = 32,
    parameter int CODE_W = 8,
    localparam int KW = $clog2(NKEYS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [KW-1:0]     wr_key,
    input  logic [CODE_W-1:0] wr_code,
    input  logic [KW-1:0]     rd_key,
    output logic [CODE_W-1:0] rd_code
);
    logic [NKEYS-1:0][CODE_W-1:0] mem;

    for (genvar g = 0; g < NKEYS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)                             mem[g] <= '0;
            else if (wr_en && wr_key == KW'(g))  mem[g] <= wr_code;
        end
    end

    assign rd_code = mem[rd_key];

    p_hold_without_write_r8: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(mem));

    p_write_lands_r8: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (mem[$past(wr_key)] == $past(wr_code)));

endmodule

// File: rtl/key_offset_cal.sv
module key_offset_cal
    import cal_pkg::*;
#(
    parameter int NKEYS  = 32,
    parameter int CODE_W = 8,
    localparam int KW = $clog2(NKEYS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_all,
    input  logic [NKEYS-1:0]  key_suspect,
    output logic              acq_req,
    output logic [KW-1:0]     acq_key,
    output logic [CODE_W-1:0] acq_code,
    input  logic              acq_done,
    input  logic              cmp_above,
    input  logic [KW-1:0]     rd_key,
    output logic [CODE_W-1:0] rd_code,
    output logic              busy
);
    cal_state_t        state;
    cal_job_t          job;
    logic              full_armed;
    logic              in_pass;
    logic [KW-1:0]     cur_key;
    logic              q_any;
    logic [KW-1:0]     q_pick;
    logic              sar_load;
    logic              sar_step;
    logic              sar_last;
    logic [CODE_W-1:0] sar_result;
    logic [CODE_W-1:0] sar_trial;
    logic              key_done;

    assign job      = pick_job(state, full_armed, in_pass, q_any);
    assign sar_load = (job != JOB_NONE);
    assign sar_step = (state == ST_TRIAL) && acq_done;
    assign key_done = sar_step && sar_last;

    cal_queue #(.NKEYS(NKEYS)) u_queue (
        .clk         (clk),
        .rst         (rst),
        .key_suspect (key_suspect),
        .take        (job == JOB_SINGLE),
        .any         (q_any),
        .pick        (q_pick)
    );

    sar_engine #(.CODE_W(CODE_W)) u_sar (
        .clk        (clk),
        .rst        (rst),
        .load       (sar_load),
        .step       (sar_step),
        .cmp_above  (cmp_above),
        .trial_code (sar_trial),
        .result     (sar_result),
        .last       (sar_last)
    );

    code_bank #(.NKEYS(NKEYS), .CODE_W(CODE_W)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (key_done),
        .wr_key  (cur_key),
        .wr_code (sar_result),
        .rd_key  (rd_key),
        .rd_code (rd_code)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            full_armed <= 1'b1;
            in_pass    <= 1'b0;
            cur_key    <= '0;
        end else begin
            full_armed <= (full_armed && job != JOB_FULL) || start_all;
            unique case (job)
                JOB_FULL: begin
                    cur_key <= '0;
                    in_pass <= 1'b1;
                    state   <= ST_TRIAL;
                end
                JOB_NEXT: begin
                    cur_key <= KW'(cur_key + 1'b1);
                    state   <= ST_TRIAL;
                end
                JOB_SINGLE: begin
                    cur_key <= q_pick;
                    state   <= ST_TRIAL;
                end
                default: ;
            endcase
            if (key_done) begin
                state <= ST_IDLE;
                if (in_pass && cur_key == KW'(NKEYS - 1)) in_pass <= 1'b0;
            end
        end
    end

    assign acq_req  = (state == ST_TRIAL);
    assign acq_key  = cur_key;
    assign acq_code = sar_trial;
    assign busy     = (state == ST_TRIAL) || full_armed || in_pass || q_any;

    p_req_held_r2: assert property (@(posedge clk) disable iff (rst)
        (acq_req && !acq_done) |=> (acq_req && $stable(acq_code) && $stable(acq_key)));

    p_busy_covers_req_r9: assert property (@(posedge clk) disable iff (rst)
        acq_req |-> busy);

    p_pass_ascends_r4: assert property (@(posedge clk) disable iff (rst)
        (job == JOB_NEXT) |=> (acq_key == KW'($past(cur_key) + 1'b1)));

    p_full_first_r7: assert property (@(posedge clk) disable iff (rst)
        (job == JOB_FULL) |=> (acq_key == '0 && in_pass));

endmodule

// File: tb/key_offset_cal_tb.sv
module key_offset_cal_tb;
    localparam int NK = 32;
    localparam int CW = 8;
    localparam int KW = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_all = 1'b0;
    logic [NK-1:0] key_suspect = '0;
    logic          acq_req;
    logic [KW-1:0] acq_key;
    logic [CW-1:0] acq_code;
    logic          acq_done = 1'b0;
    logic          cmp_above = 1'b0;
    logic [KW-1:0] rd_key = '0;
    logic [CW-1:0] rd_code;
    logic          busy;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int target [NK];
    int resp_cnt = 0;

    // behavioural reference state
    int            m_state, m_key, m_bit, m_work, m_full, m_pass;
    logic [NK-1:0] m_pend, m_sq, rel, clr;
    int            m_codes [NK];

    key_offset_cal #(.NKEYS(NK), .CODE_W(CW)) u_dut (
        .clk(clk), .rst(rst), .start_all(start_all), .key_suspect(key_suspect),
        .acq_req(acq_req), .acq_key(acq_key), .acq_code(acq_code),
        .acq_done(acq_done), .cmp_above(cmp_above), .rd_key(rd_key),
        .rd_code(rd_code), .busy(busy));

    always #4 clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // reference model, advanced on every rising edge
    always @(posedge clk) begin
        cycles++;
        rel = m_sq & ~key_suspect;
        if (rst) begin
            m_state = 0; m_key = 0; m_bit = 0; m_work = 0;
            m_full = 1; m_pass = 0; m_pend = '0; m_sq = '0;
            for (int k = 0; k < NK; k++) m_codes[k] = 0;
        end else begin
            int nfull;
            nfull = m_full;
            clr = '0;
            if (m_state == 0) begin
                if (m_full != 0) begin
                    m_key = 0; m_pass = 1; nfull = 0; m_state = 1;
                end else if (m_pass != 0) begin
                    m_key = (m_key + 1) % NK; m_state = 1;
                end else if (m_pend != 0) begin
                    for (int k = NK - 1; k >= 0; k--) if (m_pend[k]) m_key = k;
                    clr[m_key] = 1'b1; m_state = 1;
                end
                if (m_state == 1) begin m_bit = CW - 1; m_work = 0; end
            end else if (acq_done) begin
                if (cmp_above) m_work = m_work | (1 << m_bit);
                if (m_bit == 0) begin
                    m_codes[m_key] = m_work; m_state = 0;
                    if (m_pass != 0 && m_key == NK - 1) m_pass = 0;
                end else m_bit--;
            end
            m_full = nfull | int'(start_all);
            m_pend = (m_pend & ~clr) | rel;
            m_sq = key_suspect;
        end
    end

    // per-clock comparison away from the edge
    always @(negedge clk) begin
        if (!rst) begin
            check("R2 acq_req", int'(acq_req), m_state);
            if (m_state == 1) begin
                check("R2 acq_code", int'(acq_code), m_work | (1 << m_bit));
                check("R4 acq_key", int'(acq_key), m_key);
            end
            check("R9 busy", int'(busy),
                  int'(m_state == 1 || m_full != 0 || m_pass != 0 || m_pend != 0));
            check("R8 rd_code", int'(rd_code), m_codes[rd_key]);
        end
    end

    // acquisition responder: verdict is above while code <= target of the key
    always @(posedge clk) begin
        #2;
        if (acq_done) begin
            acq_done = 1'b0; resp_cnt = 0;
        end else if (acq_req && !rst) begin
            if (resp_cnt >= int'(acq_code[0]) + int'(acq_key[0])) begin
                acq_done = 1'b1;
                cmp_above = (int'(acq_code) <= target[acq_key]);
            end else resp_cnt++;
        end
    end

    always @(posedge clk) begin
        if (cycles > 150000) begin
            errors++;
            $display("FAIL R9 watchdog expired busy actual=%0b expected=0", busy);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic tick(input int n);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    task automatic wait_idle();
        int guard;
        guard = 0;
        while ((busy || acq_req) && guard < 20000) begin tick(1); guard++; end
    endtask

    task automatic wait_key(input int k);
        int guard;
        guard = 0;
        while (!(acq_req && int'(acq_key) == k) && guard < 20000) begin tick(1); guard++; end
    endtask

    task automatic check_all(input string tag);
        for (int k = 0; k < NK; k++) begin
            rd_key = KW'(k); #1;
            check(tag, int'(rd_code), target[k]);
        end
    endtask

    initial begin
        for (int k = 0; k < NK; k++) target[k] = (k * 73 + 19) % 256;
        target[0] = 0; target[1] = 255; target[2] = 128; target[3] = 127;
        tick(3);
        // R1: codes cleared, busy while reset holds the arm flag
        rd_key = 5'd7; #1;
        check("R1 reset code", int'(rd_code), 0);
        check("R1 reset busy", int'(busy), 1);
        rst = 1'b0;
        tick(1);
        check("R1 auto pass busy", int'(busy), 1);
        check("R4 first key", int'(acq_key), 0);
        wait_idle();
        check_all("R3 R4 full pass codes");

        // R6: held suspect lines queue nothing
        target[5] = 200; target[20] = 3;
        key_suspect[5] = 1'b1; key_suspect[20] = 1'b1;
        tick(5);
        check("R6 held suspect idle", int'(busy), 0);
        key_suspect[5] = 1'b0; key_suspect[20] = 1'b0;
        tick(2);
        check("R6 lowest first", int'(acq_key), 5);
        wait_key(20);
        rd_key = 5'd20; #1;
        check("R8 previous code kept", int'(rd_code), (20 * 73 + 19) % 256);
        wait_idle();
        check_all("R6 singles only");

        // R7: pass armed together with a release beats the queue
        target[3] = 64;
        key_suspect[3] = 1'b1; tick(1);
        key_suspect[3] = 1'b0; start_all = 1'b1; tick(1);
        start_all = 1'b0; tick(1);
        check("R7 pass first", int'(acq_key), 0);
        wait_idle();
        check_all("R7 after pass and queue");

        // R5: restart mid-pass
        start_all = 1'b1; tick(1); start_all = 1'b0;
        wait_key(10);
        start_all = 1'b1; tick(1); start_all = 1'b0;
        wait_key(0);
        check("R5 restart at key 0", int'(acq_key), 0);
        for (int k = 0; k < NK; k++) target[k] = (k * 29 + 5) % 256;
        wait_idle();
        check("R9 idle at end", int'(busy), 0);
        tick(2);
        start_all = 1'b1; tick(1); start_all = 1'b0;
        wait_idle();
        check_all("R3 new targets");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule